// File: doc/BRIEF.md
# Masked Interrupt Controller

This block gathers up to 32 interrupt sources into a sticky pending-status register and gates that register with an enable mask. When a pending source is also enabled, the block raises a single request line to the processor. A rising edge on a source input latches the matching status bit. Software services the interrupt by writing a 1 to that bit, which clears it. Writing 0 to a status bit leaves it as it was.

Both registers sit in the special-register address space. An address is formed as `group * 2048 + index`. The mask is at group 9, index 0 (0x4800). The status register is at group 9, index 2 (0x4802). Writes take effect on the clock edge. Reads are combinational.

The request line is driven by a two-state machine:
- `REQ_IDLE` moves to `REQ_ACTIVE` when the masked pending set becomes nonzero.
- `REQ_ACTIVE` moves back to `REQ_IDLE` when that set becomes empty.
- Each state otherwise holds.

The request output is high exactly in `REQ_ACTIVE`. Because of this state register, the request trails any status or mask change by one clock.

Top module: `pic_masked_ctrl`

## Requirements
- R1: After reset, the status register, the mask register and the request output are all zero.
- R2: A 0-to-1 change on a source input sets its status bit on that clock edge. A source held high does not set the bit again after the bit is cleared.
- R3: A write to address 0x4802 (group 9, index 2) clears each status bit whose write-data bit is 1. All other status bits keep their value.
- R4: If a rising source and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to address 0x4800 (group 9, index 0) replaces the whole mask with the write data.
- R6: The request output is high one clock after (status AND mask) is nonzero, and low one clock after it is zero. This includes the cycle right after a mask write.
- R7: The read data shows the mask at 0x4800 and the status at 0x4802, and is zero at any other address.
- R8: A write to any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Interrupt source lines; a rising edge latches the bit |
| spr_we | input | 1 | Register write strobe |
| spr_addr | input | 16 | Special-register address |
| spr_wdata | input | 32 | Write data |
| spr_rdata | output | 32 | Combinational read data |
| stat_o | output | 32 | Current status register |
| mask_o | output | 32 | Current mask register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench targets a source held high across a clear. A level-sensitive design would set the bit again immediately and keep the request stuck high.

It also targets a write that clears a bit in the same cycle that bit's source rises. A design that favours the clear would lose the interrupt.

Mask writes that enable or disable an already pending bit check that the request follows one clock later, not sooner and not never. Writes to the gap address between the two registers, and reads of it, catch a decoder that is too loose.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int unsigned GROUP_SHIFT = 11;

    function automatic logic [15:0] spr_address(input int unsigned grp, input int unsigned idx);
        return 16'((grp << GROUP_SHIFT) + idx);
    endfunction

    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_ACTIVE = 1'b1
    } req_state_e;
endpackage

// File: rtl/pic_status_bank.sv
module pic_status_bank #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] status
);
    logic [N-1:0] src_q;
    logic [N-1:0] rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src;
    end

    assign rise = src & ~src_q;

    for (genvar b = 0; b < N; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                status[b] <= 1'b0;
            else if (rise[b])
                status[b] <= 1'b1;
            else if (clr_en && clr_bits[b])
                status[b] <= 1'b0;
        end
    end

    // R2, R4: any edge seen sets its bit regardless of a concurrent clear
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(rise) & ~status) == '0));
    // R3: a clear without a competing edge empties the bit
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((status & $past(clr_bits) & ~$past(rise)) == '0));
    // R3, R8: bits fall only under a clearing write
    a_r3_no_stray_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~($past(clr_bits) & {N{$past(clr_en)}}) & ~status) == '0));
endmodule

// File: rtl/pic_req_fsm.sv
module pic_req_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic req
);
    import pic_pkg::*;

    req_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= REQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            REQ_IDLE:   if (pending)  state_nx = REQ_ACTIVE;
            REQ_ACTIVE: if (!pending) state_nx = REQ_IDLE;
            default:    state_nx = REQ_IDLE;
        endcase
        req = (state == REQ_ACTIVE);
    end

    // R6: request follows the masked pending set with one clock of lag
    a_r6_req_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req == $past(pending)));
endmodule

// File: rtl/pic_masked_ctrl.sv
module pic_masked_ctrl #(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned PIC_GROUP = 9,
    parameter int unsigned MASK_IDX  = 0,
    parameter int unsigned STAT_IDX  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               spr_we,
    input  logic [ADDR_W-1:0]  spr_addr,
    input  logic [NUM_SRC-1:0] spr_wdata,
    output logic [NUM_SRC-1:0] spr_rdata,
    output logic [NUM_SRC-1:0] stat_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               irq_o
);
    import pic_pkg::*;

    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(spr_address(PIC_GROUP, MASK_IDX));
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(spr_address(PIC_GROUP, STAT_IDX));

    logic               hit_mask, hit_stat;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] status;

    assign hit_mask = (spr_addr == MASK_ADDR);
    assign hit_stat = (spr_addr == STAT_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  mask_q <= '0;
        else if (spr_we && hit_mask) mask_q <= spr_wdata;
    end

    pic_status_bank #(.N(NUM_SRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (irq_src),
        .clr_en   (spr_we && hit_stat),
        .clr_bits (spr_wdata),
        .status   (status)
    );

    pic_req_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (|(status & mask_q)),
        .req     (irq_o)
    );

    always_comb begin
        if (hit_mask)      spr_rdata = mask_q;
        else if (hit_stat) spr_rdata = status;
        else               spr_rdata = '0;
    end

    assign stat_o = status;
    assign mask_o = mask_q;

    // R5: mask write replaces contents
    a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_we && spr_addr == MASK_ADDR) |=> (mask_o == $past(spr_wdata)));
    // R8: mask holds without its own write
    a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(spr_we && spr_addr == MASK_ADDR) |=> $stable(mask_o));
endmodule

// File: tb/pic_masked_ctrl_test.sv
module pic_masked_ctrl_test;
    localparam int PERIOD = 10;
    localparam logic [15:0] A_MASK = 16'h4800;
    localparam logic [15:0] A_STAT = 16'h4802;
    localparam logic [15:0] A_GAP  = 16'h4801;

    typedef struct packed {
        logic [31:0] src;
        logic        we;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [31:0] st;
        logic [31:0] mk;
        logic        irq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0001, 1'b0, A_GAP,  32'h0,         32'h0000_0001, 32'h0,         1'b0},
        '{32'h0000_0001, 1'b1, A_MASK, 32'h0000_0003, 32'h0000_0001, 32'h0000_0003, 1'b1},
        '{32'h0000_0001, 1'b1, A_STAT, 32'h0000_0001, 32'h0,         32'h0000_0003, 1'b0},
        '{32'h0000_0106, 1'b0, A_GAP,  32'h0,         32'h0000_0106, 32'h0000_0003, 1'b1},
        '{32'h0000_0106, 1'b1, A_STAT, 32'h0000_0002, 32'h0000_0104, 32'h0000_0003, 1'b0},
        '{32'h0000_0106, 1'b1, A_MASK, 32'h0000_0100, 32'h0000_0104, 32'h0000_0100, 1'b1},
        '{32'h0000_0006, 1'b1, A_GAP,  32'hFFFF_FFFF, 32'h0000_0104, 32'h0000_0100, 1'b1},
        '{32'h8000_0006, 1'b1, A_STAT, 32'h8000_0104, 32'h8000_0000, 32'h0000_0100, 1'b0},
        '{32'h8000_0006, 1'b1, A_MASK, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 1'b1},
        '{32'h0000_0000, 1'b1, A_MASK, 32'h0,         32'h8000_0000, 32'h0,         1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic        spr_we = 1'b0;
    logic [15:0] spr_addr = '0;
    logic [31:0] spr_wdata = '0;
    logic [31:0] spr_rdata, stat_o, mask_o;
    logic        irq_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    pic_masked_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .spr_we(spr_we),
        .spr_addr(spr_addr), .spr_wdata(spr_wdata), .spr_rdata(spr_rdata),
        .stat_o(stat_o), .mask_o(mask_o), .irq_o(irq_o)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick();
        tick();
        // R1: reset state
        check("R1 status", stat_o, 32'h0);
        check("R1 mask", mask_o, 32'h0);
        check("R1 irq", {31'h0, irq_o}, 32'h0);
        rst_n = 1'b1;
        tick();

        // vector walk: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            irq_src   = VECS[i].src;
            spr_we    = VECS[i].we;
            spr_addr  = VECS[i].addr;
            spr_wdata = VECS[i].wdata;
            tick();
            spr_we = 1'b0;
            check($sformatf("R2/R3/R4 status v%0d", i), stat_o, VECS[i].st);
            check($sformatf("R5/R8 mask v%0d", i), mask_o, VECS[i].mk);
            tick();
            check($sformatf("R6 irq v%0d", i), {31'h0, irq_o}, {31'h0, VECS[i].irq});
        end

        // R7: read path
        spr_addr = A_MASK; #1;
        check("R7 read mask", spr_rdata, 32'h0);
        irq_src = 32'h0000_0010;
        tick();
        spr_addr = A_STAT; #1;
        check("R7 read status", spr_rdata, 32'h8000_0010);
        spr_we = 1'b1; spr_addr = A_MASK; spr_wdata = 32'h0000_0010;
        tick();
        spr_we = 1'b0; #1;
        check("R7 read mask after write", spr_rdata, 32'h0000_0010);
        check("R6 irq lags mask write", {31'h0, irq_o}, 32'h0);
        spr_addr = A_GAP; #1;
        check("R7 read gap", spr_rdata, 32'h0);
        tick();
        check("R6 irq after mask write", {31'h0, irq_o}, 32'h1);

        // R1: mid-run reset
        rst_n = 1'b0;
        tick();
        check("R1 status after reset", stat_o, 32'h0);
        check("R1 mask after reset", mask_o, 32'h0);
        check("R1 irq after reset", {31'h0, irq_o}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule